// File: doc/BRIEF.md
# Recursive Karatsuba Carry-Less Multiplier

This block multiplies two binary polynomials of `N` coefficients each and returns their full carry-less product of `2N-1` coefficients, with every addition done as XOR. It is intended as the wide multiply core of a binary-field arithmetic unit. Reduction by the field polynomial is not done here; a separate fold stage consumes the unreduced product.

The product is built by recursion. An operand wider than the leaf threshold is split into a low half of `ceil(W/2)` bits and a high half of `floor(W/2)` bits. The three half-size products are the low pair, the high pair, and the pair of half sums. When the high half is one bit shorter, it is padded by a single zero bit. Below the threshold, the recursion ends in a flat form. That form XORs every single-bit product with every product of pairwise coefficient sums into its diagonal. The default width of 233 takes four split levels and ends in 15-bit and 14-bit leaves.

The multiply itself is combinational. An optional chain of output registers, with a valid bit carried alongside, retimes the result.

Top module: `hkm_mul`

## Requirements
- R1: `c` is the carry-less product of `a` and `b`: for every k, `c[k]` is the XOR over all i+j=k of `a[i] & b[j]`.
- R2: For single-coefficient operands `a = x^i` and `b = x^j`, `c` holds exactly one set bit, at position i+j. This includes the top position 2N-2 when both inputs have only their top bit set.
- R3: R1 also holds for a small odd width whose recursion mixes split levels, padded middle products and flat leaves (N=13, leaf threshold 4).
- R4: If either operand is all zeros, `c` is all zeros.
- R5: The XOR of all bits of `c` equals the AND of the XOR of all bits of `a` and the XOR of all bits of `b`.
- R6: If `b` equals 1 (only bit 0 set), `c` equals `a` zero-extended.
- R7: With `STAGES` output registers, the product and `out_valid` for operands presented with `in_valid` high at a clock edge appear `STAGES` edges later. `out_valid` stays low at the edges in between. With `STAGES` = 0, the path is combinational.
- R8: While `rst_n` is low, `out_valid` is low (when `STAGES` is at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register chain |
| rst_n | input | 1 | Asynchronous active-low reset of the valid chain |
| in_valid | input | 1 | Marks `a` and `b` as a product request |
| a | input | N | First polynomial operand, bit i is the coefficient of x^i |
| b | input | N | Second polynomial operand |
| out_valid | output | 1 | Marks `c` as a finished product |
| c | output | 2N-1 | Unreduced carry-less product |

## Verification
The clocked checks watch the unregistered product against the operands at every edge. They therefore assume that `a` and `b` are settled and known at each rising edge, whether or not `in_valid` is high. The bench changes operands only at falling edges and holds them steady through the next rising edge. The data registers carry no reset, so the product identities are checked against the operands at the input, never against the delayed output.

// File: rtl/hkm_core.sv
module hkm_core #(
  parameter int W   = 233,
  parameter int THR = 29
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] c
);
  localparam int CW = 2*W - 1;

  generate
    if (W < THR) begin : g_flat
      always_comb begin
        c = '0;
        for (int i = 0; i < W; i++) begin
          c[2*i] = c[2*i] ^ (a[i] & b[i]);
          for (int j = i + 1; j < W; j++) begin
            c[i+j] = c[i+j] ^ ((a[i] ^ a[j]) & (b[i] ^ b[j]))
                            ^ (a[i] & b[i]) ^ (a[j] & b[j]);
          end
        end
      end
    end else begin : g_split
      localparam int H  = (W + 1) / 2;
      localparam int L  = W - H;
      localparam int HW = 2*H - 1;
      localparam int LW = 2*L - 1;

      logic [H-1:0]  a_lo, b_lo, a_sum, b_sum;
      logic [L-1:0]  a_hi, b_hi;
      logic [HW-1:0] p_lo, p_sum, p_mid;
      logic [LW-1:0] p_hi;

      assign a_lo  = a[H-1:0];
      assign b_lo  = b[H-1:0];
      assign a_hi  = a[W-1:H];
      assign b_hi  = b[W-1:H];
      assign a_sum = a_lo ^ H'(a_hi);
      assign b_sum = b_lo ^ H'(b_hi);

      hkm_core #(.W(H), .THR(THR)) u_lo  (.a(a_lo),  .b(b_lo),  .c(p_lo));
      hkm_core #(.W(L), .THR(THR)) u_hi  (.a(a_hi),  .b(b_hi),  .c(p_hi));
      hkm_core #(.W(H), .THR(THR)) u_sum (.a(a_sum), .b(b_sum), .c(p_sum));

      assign p_mid = p_sum ^ p_lo ^ HW'(p_hi);
      assign c = CW'(p_lo) ^ (CW'(p_mid) << H) ^ (CW'(p_hi) << (2*H));
    end
  endgenerate
endmodule

// File: rtl/hkm_mul.sv
module hkm_mul #(
  parameter int N      = 233,
  parameter int THR    = 29,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  output logic [2*N-2:0] c
);
  localparam int CW = 2*N - 1;

  logic [CW-1:0] prod;

  hkm_core #(.W(N), .THR(THR)) u_core (.a(a), .b(b), .c(prod));

  generate
    if (STAGES == 0) begin : g_comb
      assign c         = prod;
      assign out_valid = in_valid;
    end else begin : g_pipe
      logic [CW-1:0] c_q [STAGES];
      logic          v_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) v_q[s] <= 1'b0;
        end else begin
          v_q[0] <= in_valid;
          for (int s = 1; s < STAGES; s++) v_q[s] <= v_q[s-1];
        end
      end

      always_ff @(posedge clk) begin
        c_q[0] <= prod;
        for (int s = 1; s < STAGES; s++) c_q[s] <= c_q[s-1];
      end

      assign c         = c_q[STAGES-1];
      assign out_valid = v_q[STAGES-1];

      always @(posedge clk) begin
        if (!rst_n) begin
          p_valid_clear_r8: assert (!out_valid);
        end
      end
    end
  endgenerate

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a == '0 || b == '0) |-> (prod == '0));

  p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (^prod) == ((^a) & (^b)));

  p_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b == N'(1)) |-> (prod == CW'(a)));

  p_top_coef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prod[CW-1] == (a[N-1] & b[N-1]));

  p_low_coef_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prod[0] == (a[0] & b[0]));
endmodule

// File: tb/hkm_mul_tb_top.sv
`timescale 1ns/1ps
module hkm_mul_tb_top;
  localparam int N  = 233;
  localparam int CW = 2*N - 1;
  localparam int NS = 13;
  localparam int CS = 2*NS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic out_valid;
  logic [CW-1:0] c;

  logic [NS-1:0] sa = '0, sb = '0;
  logic s_valid;
  logic [CS-1:0] sc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hkm_mul #(.N(N), .THR(29), .STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .c(c));

  hkm_mul #(.N(NS), .THR(4), .STAGES(0)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .a(sa), .b(sb),
    .out_valid(s_valid), .c(sc));

  function automatic logic [CW-1:0] clmul(input logic [N-1:0] x,
                                          input logic [N-1:0] y);
    logic [CW-1:0] r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        r[i+j] = r[i+j] ^ (x[i] & y[j]);
    return r;
  endfunction

  function automatic logic [N-1:0] rnd_big();
    logic [255:0] w;
    for (int k = 0; k < 8; k++) w[k*32 +: 32] = $urandom;
    return w[N-1:0];
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [CW-1:0] act,
                           input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_big(input string req, input logic [N-1:0] x,
                         input logic [N-1:0] y, input logic [CW-1:0] exp);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R7 early", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R7 valid", out_valid, 1'b1);
    check_vec(req, c, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_bit("R8", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_bit("R7 idle", out_valid, 1'b0);
  endtask

  task automatic t_zero();
    logic [N-1:0] r = rnd_big();
    run_big("R4 a zero", '0, r, '0);
    run_big("R4 b zero", r, '0, '0);
  endtask

  task automatic t_ones();
    logic [N-1:0] ones = '1;
    run_big("R1 ones", ones, ones, clmul(ones, ones));
  endtask

  task automatic t_unit();
    logic [N-1:0] r = rnd_big();
    run_big("R6 unit", r, N'(1), CW'(r));
  endtask

  task automatic t_single_bits();
    int pos [6] = '{0, 1, 14, 116, 117, N-1};
    foreach (pos[p]) begin
      foreach (pos[q]) begin
        logic [CW-1:0] e = '0;
        e[pos[p] + pos[q]] = 1'b1;
        run_big("R2 single", N'(1) << pos[p], N'(1) << pos[q], e);
      end
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      logic [N-1:0] x = rnd_big();
      logic [N-1:0] y = rnd_big();
      logic [CW-1:0] e = clmul(x, y);
      run_big("R1 random", x, y, e);
      check_bit("R5 parity", ^e, (^x) & (^y));
    end
  endtask

  task automatic t_back_to_back();
    logic [N-1:0] x0 = rnd_big(), y0 = rnd_big();
    logic [N-1:0] x1 = rnd_big(), y1 = rnd_big();
    @(negedge clk);
    a = x0; b = y0; in_valid = 1'b1;
    @(negedge clk);
    a = x1; b = y1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R7 stream0 valid", out_valid, 1'b1);
    check_vec("R7 stream0", c, clmul(x0, y0));
    @(negedge clk);
    check_bit("R7 stream1 valid", out_valid, 1'b1);
    check_vec("R7 stream1", c, clmul(x1, y1));
    @(negedge clk);
    check_bit("R7 drain", out_valid, 1'b0);
  endtask

  task automatic t_small();
    for (int n = 0; n < 300; n++) begin
      logic [NS-1:0] x = NS'($urandom);
      logic [NS-1:0] y = NS'($urandom);
      if (n == 0) begin x = '1; y = '1; end
      if (n == 1) begin x = NS'(1) << (NS-1); y = x; end
      @(negedge clk);
      sa = x; sb = y;
      #1;
      check_vec("R3 small", CW'(sc), CW'(clmul(N'(x), N'(y))));
    end
    check_bit("R7 comb valid", s_valid, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero();
    t_ones();
    t_unit();
    t_single_bits();
    t_random();
    t_back_to_back();
    t_small();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule